// File: doc/BRIEF.md
# Six-Voice Wavetable Tone Generator

This block produces audio from six independent wavetable voices. Each voice owns a small waveform store of 32 five-bit samples. Each voice also has a 12-bit step period, an on/off control, a five-bit loudness and a pair of four-bit left and right balance levels. A byte-wide, write-only register file sets all of this up. A voice-select register chooses which voice the per-voice registers reach.

To load a waveform, software disables the voice and, if needed, sets its write pointer back to the first entry through the control register. It then writes the samples one after another to a single data register, and the pointer steps forward on each write. Once the voice is switched on, it walks through its waveform at the programmed rate. Each voice is scaled by its loudness and balance levels. The six voices are summed, and the sums are scaled by a global left and right main level. The result comes out as two registered, unsigned words that are wide enough never to overflow.

Top module: `wavetone_mixer`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are zero, every voice is disabled, and every write pointer and play position is at entry 0.
- R2: A write to address 0 loads the voice selector from data bits [2:0]. Writes to addresses 2 to 6 reach only the selected voice. Selector values 6 and 7 reach no voice, and addresses 7 to 15 change nothing.
- R3: Address 1 holds the global main levels: left in bits [7:4], right in bits [3:0]. A change of main level shows on the outputs one cycle after the write edge.
- R4: The step period is 12 bits. Address 2 writes bits [7:0], address 3 bits [3:0] write bits [11:8], and address 3 bits [7:4] are ignored. While a voice is enabled, its play position advances by one, modulo 32, once every period+1 clock cycles.
- R5: Address 4 is the voice control register: bit 7 enables playback, bit 6 = 1 returns the waveform write pointer to entry 0, and bits [4:0] set the voice loudness.
- R6: Address 5 sets the voice balance: left in bits [7:4], right in bits [3:0].
- R7: A write to address 6 while the voice is disabled stores data bits [4:0] at the write pointer and advances the pointer, wrapping from 31 to 0. While the voice is enabled, such a write is ignored and the pointer does not move.
- R8: Each output equals the sum, over the enabled voices, of sample × loudness × voice balance level × main level for that side. It never overflows its 21-bit width.
- R9: A disabled voice adds zero to both outputs, and its play position is held at 0, so playback after enable starts at entry 0.
- R10: The outputs are registered: they reflect the voice state as it was before the most recent clock edge. In the cycle right after the enabling edge the output therefore still shows the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| out_left | output | 21 | Mixed left output |
| out_right | output | 21 | Mixed right output |

## Verification
The bench sweeps every voice through a full 32-entry waveform. It uses step period 0 and different loudness, balance and main levels, and computes each expected product arithmetically. A mixing or scaling error would give wrong words on almost every cycle. Long and short periods test the step timing, where an off-by-one counter would drift out of phase within a few steps. Writes are aimed at selector values 6 and 7 and at a voice that is playing; a design that aliased the selector or did not guard the waveform store would corrupt a voice that is audible later. Pointer wrap, pointer reset, re-enable from entry 0 and all voices at full scale are checked as well. A design that got these wrong would start playback at the wrong sample or truncate the sum.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [3:0] {
    A_SEL  = 4'd0,
    A_MAIN = 4'd1,
    A_PLO  = 4'd2,
    A_PHI  = 4'd3,
    A_CTRL = 4'd4,
    A_BAL  = 4'd5,
    A_WAVE = 4'd6
  } wt_addr_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_RST_BIT = 6;
endpackage

// File: rtl/wt_chan.sv
module wt_chan #(
  parameter int DEPTH = 32,
  parameter int SW    = 5,
  parameter int PW    = 12,
  parameter int VW    = 5,
  parameter int BW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_plo,
  input  logic                  we_phi,
  input  logic                  we_ctrl,
  input  logic                  we_bal,
  input  logic                  we_wave,
  input  logic [7:0]            wdata,
  output logic [SW+VW+BW-1:0]   term_l,
  output logic [SW+VW+BW-1:0]   term_r
);
  import wt_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = SW + VW;
  localparam int TW    = SW + VW + BW;

  logic [PW-1:0]    period_q, period_d;
  logic [PW-1:0]    cnt_q, cnt_d;
  logic             en_q, en_d;
  logic [VW-1:0]    vol_q, vol_d;
  logic [BW-1:0]    bal_l_q, bal_l_d, bal_r_q, bal_r_d;
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] pidx_q, pidx_d;
  logic             wave_we;
  logic [SW-1:0]    wave_q [DEPTH];
  logic [SW-1:0]    sample;
  logic [LVL_W-1:0] lvl;

  assign wave_we = we_wave && !en_q;

  // next-state
  always_comb begin
    period_d = period_q;
    en_d     = en_q;
    vol_d    = vol_q;
    bal_l_d  = bal_l_q;
    bal_r_d  = bal_r_q;
    wptr_d   = wptr_q;
    if (we_plo) period_d[7:0] = wdata;
    if (we_phi) period_d[PW-1:8] = wdata[PW-9:0];
    if (we_ctrl) begin
      en_d  = wdata[CTRL_EN_BIT];
      vol_d = wdata[VW-1:0];
      if (wdata[CTRL_RST_BIT]) wptr_d = '0;
    end
    if (we_bal) begin
      bal_l_d = wdata[7:4];
      bal_r_d = wdata[3:0];
    end
    if (wave_we) wptr_d = wptr_q + 1'b1;
    if (!en_q) begin
      cnt_d  = period_q;
      pidx_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d  = period_q;
      pidx_d = pidx_q + 1'b1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      pidx_d = pidx_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      vol_q    <= '0;
      bal_l_q  <= '0;
      bal_r_q  <= '0;
      wptr_q   <= '0;
      pidx_q   <= '0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
      en_q     <= en_d;
      vol_q    <= vol_d;
      bal_l_q  <= bal_l_d;
      bal_r_q  <= bal_r_d;
      wptr_q   <= wptr_d;
      pidx_q   <= pidx_d;
    end
  end

  // waveform store, written only through its enable
  always_ff @(posedge clk) begin
    if (wave_we) wave_q[wptr_q] <= wdata[SW-1:0];
  end

  always_comb begin
    sample = en_q ? wave_q[pidx_q] : '0;
    lvl    = LVL_W'(sample) * LVL_W'(vol_q);
    term_l = TW'(lvl) * TW'(bal_l_q);
    term_r = TW'(lvl) * TW'(bal_r_q);
  end

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pidx_q == '0));
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0) |=> (pidx_q == $past(pidx_q) + 1'b1));
  p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q != '0) |=> ((cnt_q == $past(cnt_q) - 1'b1) && $stable(pidx_q)));
  p_wave_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wave && en_q) |=> $stable(wptr_q));
  p_wptr_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wave && !en_q) |=> (wptr_q == $past(wptr_q) + 1'b1));
endmodule

// File: rtl/wt_mix.sv
module wt_mix #(
  parameter int NCH = 6,
  parameter int TW  = 14,
  parameter int BW  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NCH*TW-1:0]                     terms_l,
  input  logic [NCH*TW-1:0]                     terms_r,
  input  logic [BW-1:0]                         main_l,
  input  logic [BW-1:0]                         main_r,
  output logic [TW+BW+$clog2(NCH+1)-1:0]        out_l,
  output logic [TW+BW+$clog2(NCH+1)-1:0]        out_r
);
  localparam int SUM_W = TW + $clog2(NCH + 1);
  localparam int OW    = SUM_W + BW;

  logic [SUM_W-1:0] sum_l, sum_r;
  logic [OW-1:0]    mix_l_d, mix_r_d;

  always_comb begin
    sum_l = '0;
    sum_r = '0;
    for (int i = 0; i < NCH; i++) begin
      sum_l = sum_l + SUM_W'(terms_l[i*TW +: TW]);
      sum_r = sum_r + SUM_W'(terms_r[i*TW +: TW]);
    end
    mix_l_d = OW'(sum_l) * OW'(main_l);
    mix_r_d = OW'(sum_r) * OW'(main_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l <= '0;
      out_r <= '0;
    end else begin
      out_l <= mix_l_d;
      out_r <= mix_r_d;
    end
  end

  p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (terms_l == '0 && terms_r == '0) |=> (out_l == '0 && out_r == '0));
  p_main_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_l == '0) |=> (out_l == '0));
endmodule

// File: rtl/wavetone_mixer.sv
module wavetone_mixer #(
  parameter int NCH   = 6,
  parameter int DEPTH = 32,
  parameter int SW    = 5,
  parameter int PW    = 12,
  parameter int VW    = 5,
  parameter int BW    = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en,
  input  logic [3:0]                               wr_addr,
  input  logic [7:0]                               wr_data,
  output logic [SW+VW+2*BW+$clog2(NCH+1)-1:0]      out_left,
  output logic [SW+VW+2*BW+$clog2(NCH+1)-1:0]      out_right
);
  import wt_pkg::*;

  localparam int TW    = SW + VW + BW;
  localparam int SEL_W = 3;

  logic             rs1_q, rs2_q, rst_i;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [BW-1:0]    main_l_q, main_l_d, main_r_q, main_r_d;
  logic [NCH*TW-1:0] terms_l, terms_r;

  // reset: asserts at once, releases after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  always_comb begin
    sel_d    = sel_q;
    main_l_d = main_l_q;
    main_r_d = main_r_q;
    if (wr_en && wr_addr == A_SEL) sel_d = wr_data[SEL_W-1:0];
    if (wr_en && wr_addr == A_MAIN) begin
      main_l_d = wr_data[7:4];
      main_r_d = wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_q    <= '0;
      main_l_q <= '0;
      main_r_q <= '0;
    end else begin
      sel_q    <= sel_d;
      main_l_q <= main_l_d;
      main_r_q <= main_r_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = wr_en && (sel_q == SEL_W'(ch));

    wt_chan #(
      .DEPTH(DEPTH), .SW(SW), .PW(PW), .VW(VW), .BW(BW)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_i),
      .we_plo  (hit && wr_addr == A_PLO),
      .we_phi  (hit && wr_addr == A_PHI),
      .we_ctrl (hit && wr_addr == A_CTRL),
      .we_bal  (hit && wr_addr == A_BAL),
      .we_wave (hit && wr_addr == A_WAVE),
      .wdata   (wr_data),
      .term_l  (terms_l[ch*TW +: TW]),
      .term_r  (terms_r[ch*TW +: TW])
    );
  end

  wt_mix #(.NCH(NCH), .TW(TW), .BW(BW)) u_mix (
    .clk     (clk),
    .rst_n   (rst_i),
    .terms_l (terms_l),
    .terms_r (terms_r),
    .main_l  (main_l_q),
    .main_r  (main_r_q),
    .out_l   (out_left),
    .out_r   (out_right)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i |=> (out_left == '0 && out_right == '0));
endmodule

// File: tb/sim_wavetone_mixer.sv
module sim_wavetone_mixer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [20:0] out_left, out_right;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int wave_m [6][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  wavetone_mixer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_left(out_left), .out_right(out_right)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input int el, input int er);
    checks++;
    if (int'(out_left) != el || int'(out_right) != er) begin
      fails++;
      $display("FAIL %s: left %0d exp %0d, right %0d exp %0d",
               tag, out_left, el, out_right, er);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic int wv(input int ch, input int i);
    return (i * 5 + ch * 3 + 1) % 32;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, exp completion");
      summary();
    end
  end

  initial begin
    int vol, bl, br, ml, mr, per, unit;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 0, 0);

    // per-voice sweep, step period 0 (upper bits of address 3 set and ignored)
    for (int ch = 0; ch < 6; ch++) begin
      vol = 31 - ch * 5; bl = 15 - ch; br = ch * 3; ml = 15 - ch * 2; mr = ch + 10;
      wr(4'd0, 8'hF8 | 8'(ch));
      wr(4'd4, 8'h40);
      for (int i = 0; i < 32; i++) begin
        wr(4'd6, 8'hE0 | 8'(wv(ch, i)));
        wave_m[ch][i] = wv(ch, i);
      end
      wr(4'd2, 8'h00);
      wr(4'd3, 8'hF0);
      wr(4'd5, 8'((bl << 4) | br));
      wr(4'd1, 8'((ml << 4) | mr));
      wr(4'd4, 8'h80 | 8'(vol));
      chk("R10 first cycle after enable", 0, 0);
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk);
        chk("R8 sweep", wave_m[ch][(n-1)%32]*vol*bl*ml, wave_m[ch][(n-1)%32]*vol*br*mr);
      end
      wr(4'd4, 8'h00);
      for (int n = 1; n <= 2; n++) begin
        @(negedge clk);
        chk("R9 disabled silent", 0, 0);
      end
    end

    // selector 6 and 7 reach no voice; address 9 does nothing
    wr(4'd0, 8'h06); wr(4'd4, 8'h9F); wr(4'd5, 8'hFF);
    wr(4'd0, 8'h07); wr(4'd4, 8'h9F); wr(4'd9, 8'hFF);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R2 unmapped selector", 0, 0);
    end

    // long and short step periods on voice 2 (vol 21, balance 13/6)
    wr(4'd1, 8'hFF);
    wr(4'd0, 8'h02);
    wr(4'd2, 8'h02); wr(4'd3, 8'hF1);
    per = 258; unit = 21 * 15;
    wr(4'd4, 8'h95);
    for (int n = 1; n <= 700; n++) begin
      @(negedge clk);
      chk("R4 period 258", wave_m[2][((n-1)/(per+1))%32]*unit*13, wave_m[2][((n-1)/(per+1))%32]*unit*6);
    end
    wr(4'd4, 8'h15);
    wr(4'd2, 8'h03); wr(4'd3, 8'h00);
    per = 3;
    wr(4'd4, 8'h95);
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      chk("R4 period 3", wave_m[2][((n-1)/(per+1))%32]*unit*13, wave_m[2][((n-1)/(per+1))%32]*unit*6);
    end

    // waveform writes while playing are ignored; pointer wrapped to 0
    for (int k = 0; k < 8; k++) wr(4'd6, 8'h00);
    wr(4'd4, 8'h15);
    wr(4'd6, 8'd30); wave_m[2][0] = 30;
    wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    wr(4'd4, 8'h95);
    for (int n = 1; n <= 34; n++) begin
      @(negedge clk);
      chk("R7 ignore and wrap", wave_m[2][(n-1)%32]*unit*13, wave_m[2][(n-1)%32]*unit*6);
    end

    // pointer reset through control bit 6
    wr(4'd4, 8'h15);
    for (int k = 1; k <= 5; k++) begin
      wr(4'd6, 8'(19 + k)); wave_m[2][k] = 19 + k;
    end
    wr(4'd4, 8'h55);
    wr(4'd6, 8'd2); wave_m[2][0] = 2;
    wr(4'd4, 8'h95);
    for (int n = 1; n <= 34; n++) begin
      @(negedge clk);
      chk("R5 pointer reset", wave_m[2][(n-1)%32]*unit*13, wave_m[2][(n-1)%32]*unit*6);
    end
    wr(4'd4, 8'h15);
    @(negedge clk);
    @(negedge clk);
    chk("R9 silent after disable", 0, 0);

    // all voices at full scale
    for (int ch = 0; ch < 6; ch++) begin
      wr(4'd0, 8'(ch)); wr(4'd4, 8'h40);
      for (int i = 0; i < 32; i++) wr(4'd6, 8'd31);
      wr(4'd5, 8'hFF); wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    end
    for (int ch = 0; ch < 6; ch++) begin
      wr(4'd0, 8'(ch)); wr(4'd4, 8'h9F);
      @(negedge clk);
      chk("R8 full-scale sum", (ch+1)*216225, (ch+1)*216225);
    end
    wr(4'd1, 8'h3C);
    @(negedge clk);
    chk("R3 main level", 6*31*31*15*3, 6*31*31*15*12);
    chk("R6 balance right", 6*31*31*15*3, 6*31*31*15*12);

    done = 1;
    summary();
  end
endmodule